// File: doc/BRIEF.md
# Measurement Register Read Target for a Two-Wire Bus

This block lets an external host read a bank of 22 eight-bit measurement values over an I2C bus. The block is a target only. It answers to a fixed 7-bit address. A write transaction carries a one-byte register index. A read transaction returns bytes starting at that index, and the index steps forward after every byte, so a long burst needs no further index writes. After the last register the index returns to register 0.

The block samples both bus lines with a system clock that runs much faster than SCL. Each line first passes through a two-flop synchroniser and then through a counting spike filter. The filter throws away any pulse that is shorter than `FILT_LEN` system clocks. Choose `FILT_LEN` so that `FILT_LEN` clock periods add up to at least 60 ns, for example 4 at 50 MHz. All protocol decoding uses the filtered lines, and it works for both 100 kHz and 400 kHz bus timing. SDA is open-drain: `sda_oe_o` high pulls the line low.

Reads never come from the live measurement inputs. They come from a shadow copy of all 22 values, which is reloaded at the rising edge of the vertical sync input. Everything read between two vertical sync edges therefore belongs to the same field.

Top module: `i2c_meas_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper 7 bits equal 0x3A, which gives 0x74 for a write and 0x75 for a read. Any other address gets no ACK, and the target leaves SDA alone until the next START or STOP.
- R2: In a write transaction, the first data byte after the address is loaded into the register index. A value of 22 or more loads index 0.
- R3: Data bytes after the first one in a write transaction are acknowledged and thrown away. The index stays unchanged.
- R4: In a read transaction, the target sends the register at the current index, MSB first, and then increments the index. Consecutive bytes return consecutive registers.
- R5: A read of register 21 is followed by a read of register 0.
- R6: If the host NACKs a read byte, the transfer ends. The target keeps SDA released until the next START or STOP.
- R7: A repeated START, sent without a STOP, restarts address matching. A write of the index followed by a repeated START and a read returns the register that was just selected.
- R8: A pulse on SCL or on SDA shorter than `FILT_LEN` system clocks has no effect on the protocol. This includes the pulses that would otherwise look like an extra clock, a START or a STOP.
- R9: The shadow bank loads all 22 measurement inputs at a rising edge of `vsync_i`. At all other times it holds its contents, so a change on `meas_i` is not visible in reads until the next rising edge.
- R10: After reset, SDA is released, the index is 0 and every shadow register is 0.
- R11: A STOP, or a START seen in any state, releases SDA in the next cycle. A transaction that is cut short by a STOP leaves the index unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level (raw, asynchronous) |
| sda_i | input | 1 | SDA line level (raw, asynchronous) |
| sda_oe_o | output | 1 | When high, pulls SDA low (open-drain) |
| vsync_i | input | 1 | Vertical sync; its rising edge loads the shadow bank |
| meas_i | input | NREG*8 | Live measurements; register i is at bits [8i+7:8i] |

## Verification
The bench fires pulses two clocks wide on SCL and on SDA inside every bit of a write, at times when SCL is high. A weak filter would then count an extra bit or see a false START or STOP, and the index written afterwards would read back wrong. Several boundary reads are covered: an index of 21 followed by a wrap to 0, an index of 30 that must fall back to 0, and extra write bytes that must not move the index. A target that increments or stores at the wrong moment returns the neighbouring register. The bench also changes `meas_i` with no vsync edge, where a design without a working shadow would return the new value. It checks that SDA stays released for a full byte of clocks after a host NACK, where a design that keeps shifting would drive zeros onto the bus.

// File: rtl/i2c_meas_pkg.sv
package i2c_meas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } tgt_state_t;
endpackage

// File: rtl/i2c_spike_filter.sv
module i2c_spike_filter #(
  parameter int FILT_LEN = 4,
  parameter bit RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {2{RST_VAL}};
      cnt_q  <= '0;
      filt_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] != filt_q) begin
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          filt_q <= sync_q[1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign filt_o = filt_q;

  // R8
  filt_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(sync_q[1]) == filt_q));
endmodule

// File: rtl/meas_snapshot.sv
module meas_snapshot #(
  parameter int NREG = 22,
  parameter int DW   = 8,
  localparam int PW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vsync_i,
  input  logic [NREG*DW-1:0] meas_i,
  input  logic [PW-1:0]      rd_idx,
  output logic [DW-1:0]      rd_data
);
  logic [2:0]         vs_q;
  logic               cap;
  logic [NREG*DW-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_q <= '0;
    else        vs_q <= {vs_q[1:0], vsync_i};
  end

  assign cap = vs_q[1] & ~vs_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   shadow_q <= '0;
    else if (cap) shadow_q <= meas_i;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == PW'(i)) rd_data = shadow_q[i*DW +: DW];
  end

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(shadow_q));
endmodule

// File: rtl/i2c_rd_target.sv
module i2c_rd_target
  import i2c_meas_pkg::*;
#(
  parameter int         NREG     = 22,
  parameter logic [6:0] DEV_ADDR = 7'h3A,
  localparam int        PW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic [7:0]    rd_data,
  output logic [PW-1:0] rd_idx,
  output logic          sda_oe
);
  tgt_state_t    state_q;
  logic          scl_q, sda_q;
  logic [3:0]    cnt_q;
  logic [7:0]    sh_q;
  logic [PW-1:0] ptr_q;
  logic          first_q, rw_q, nack_q, oe_q;
  logic          start_evt, stop_evt, rise, fall;

  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
  assign rise      = scl_f & ~scl_q;
  assign fall      = ~scl_f & scl_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(NREG - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      first_q <= 1'b0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (start_evt) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
        first_q <= 1'b1;
      end else if (stop_evt) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (rise) begin
              sh_q  <= {sh_q[6:0], sda_f};
              cnt_q <= cnt_q + 1'b1;
            end else if (fall && cnt_q == 4'd8) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                oe_q    <= 1'b1;
                rw_q    <= sh_q[0];
                state_q <= ST_AACK;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          ST_AACK, ST_RACK: begin
            if (rise && state_q == ST_RACK) nack_q <= sda_f;
            if (fall) begin
              cnt_q <= '0;
              if (state_q == ST_AACK && !rw_q) begin
                oe_q    <= 1'b0;
                state_q <= ST_WDAT;
              end else if (state_q == ST_RACK && nack_q) begin
                oe_q    <= 1'b0;
                state_q <= ST_SKIP;
              end else begin
                sh_q    <= rd_data;
                oe_q    <= ~rd_data[7];
                ptr_q   <= nxt(ptr_q);
                state_q <= ST_RDAT;
              end
            end
          end
          ST_WDAT: begin
            if (rise) begin
              sh_q  <= {sh_q[6:0], sda_f};
              cnt_q <= cnt_q + 1'b1;
            end else if (fall && cnt_q == 4'd8) begin
              oe_q    <= 1'b1;
              state_q <= ST_WACK;
              first_q <= 1'b0;
              if (first_q) ptr_q <= (sh_q < 8'(NREG)) ? sh_q[PW-1:0] : '0;
            end
          end
          ST_WACK: begin
            if (fall) begin
              oe_q    <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (fall) begin
              if (cnt_q == 4'd8) begin
                oe_q    <= 1'b0;
                state_q <= ST_RACK;
              end else begin
                sh_q <= {sh_q[6:0], 1'b0};
                oe_q <= ~sh_q[6];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_idx = ptr_q;
  assign sda_oe = oe_q;

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt || start_evt) |=> !oe_q);
  // R6
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP || state_q == ST_IDLE) |-> !oe_q);
  // R5
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q < PW'(NREG));
  // R1
  ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oe_q) && $past(state_q) == ST_ADDR) |-> ($past(sh_q[7:1]) == DEV_ADDR));
endmodule

// File: rtl/i2c_meas_target.sv
module i2c_meas_target #(
  parameter int         NREG     = 22,
  parameter int         FILT_LEN = 4,
  parameter logic [6:0] DEV_ADDR = 7'h3A,
  localparam int        PW       = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              vsync_i,
  input  logic [NREG*8-1:0] meas_i
);
  logic          scl_f, sda_f;
  logic [PW-1:0] rd_idx;
  logic [7:0]    rd_data;

  i2c_spike_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .filt_o(scl_f));

  i2c_spike_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .filt_o(sda_f));

  meas_snapshot #(.NREG(NREG), .DW(8)) u_snap (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .meas_i(meas_i),
    .rd_idx(rd_idx), .rd_data(rd_data));

  i2c_rd_target #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .rd_data(rd_data), .rd_idx(rd_idx), .sda_oe(sda_oe_o));
endmodule

// File: tb/i2c_meas_target_bench.sv
module i2c_meas_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 22;
  localparam int Q          = 25;
  localparam int WDOG       = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic vsync = 1'b0;
  logic sda_oe;
  logic sda_bus;
  logic [NREG*8-1:0] meas;
  int gen = 0;
  int snap_gen = -1;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus = sda_drv & ~sda_oe;

  function automatic logic [7:0] mval(input int i, input int g);
    return 8'(i * 13 + g * 85 + 1);
  endfunction

  function automatic logic [7:0] expv(input int i);
    return (snap_gen < 0) ? 8'h00 : mval(i, snap_gen);
  endfunction

  always_comb
    for (int i = 0; i < NREG; i++) meas[i*8 +: 8] = mval(i, gen);

  i2c_meas_target #(.NREG(NREG), .FILT_LEN(4), .DEV_ADDR(7'h3A)) u_i2c_meas_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .vsync_i(vsync), .meas_i(meas));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_out(input logic b, input bit glitch);
    sda_drv = b; qwait;
    scl_drv = 1'b1;
    if (glitch) begin
      repeat (12) @(negedge clk);
      scl_drv = 1'b0; repeat (2) @(negedge clk); scl_drv = 1'b1;
      repeat (12) @(negedge clk);
      sda_drv = ~b; repeat (2) @(negedge clk); sda_drv = b;
      repeat (2*Q - 28) @(negedge clk);
    end else begin
      qwait; qwait;
    end
    scl_drv = 1'b0; qwait;
  endtask

  task automatic bit_in(output logic b);
    sda_drv = 1'b1; qwait;
    scl_drv = 1'b1; qwait;
    b = sda_bus; qwait;
    scl_drv = 1'b0; qwait;
  endtask

  task automatic i2c_start;
    sda_drv = 1'b1; qwait;
    scl_drv = 1'b1; qwait;
    sda_drv = 1'b0; qwait;
    scl_drv = 1'b0; qwait;
  endtask

  task automatic i2c_stop;
    scl_drv = 1'b0; sda_drv = 1'b0; qwait;
    scl_drv = 1'b1; qwait;
    sda_drv = 1'b1; qwait; qwait;
  endtask

  task automatic send_byte(input logic [7:0] v, input bit glitch, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i], glitch);
    bit_in(a);
    ack = !a;
  endtask

  task automatic recv_byte(input bit host_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      bit_in(b);
      v[i] = b;
    end
    bit_out(!host_ack, 1'b0);
  endtask

  task automatic set_ptr(input logic [7:0] p, input string req);
    bit ack;
    i2c_start;
    send_byte(8'h74, 1'b0, ack); chk({req, " write address ACK (R1)"}, ack, 1);
    send_byte(p, 1'b0, ack);     chk({req, " index byte ACK"}, ack, 1);
    i2c_stop;
  endtask

  task automatic read_seq(input int start_idx, input int n, input string req);
    bit ack;
    logic [7:0] v;
    i2c_start;
    send_byte(8'h75, 1'b0, ack); chk({req, " read address ACK (R1)"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, v);
      chk(req, v, expv((start_idx + k) % NREG));
    end
    i2c_stop;
    chk({req, " SDA released after STOP (R11)"}, sda_oe, 0);
  endtask

  task automatic t_reset;
    chk("R10 SDA released at reset", sda_oe, 0);
    read_seq(0, 1, "R10 zero shadow, index 0");
  endtask

  task automatic t_burst;
    vsync = 1'b1; repeat (5) @(negedge clk); vsync = 1'b0;
    repeat (10) @(negedge clk);
    snap_gen = gen;
    set_ptr(8'd0, "R2");
    read_seq(0, 4, "R4 auto-increment burst");
  endtask

  task automatic t_snapshot;
    gen = 1;
    repeat (10) @(negedge clk);
    set_ptr(8'd5, "R9");
    read_seq(5, 1, "R9 old value held without vsync");
    vsync = 1'b1; repeat (5) @(negedge clk); vsync = 1'b0;
    repeat (10) @(negedge clk);
    snap_gen = 1;
    set_ptr(8'd5, "R9");
    read_seq(5, 2, "R9 new value after vsync edge");
  endtask

  task automatic t_wrap;
    set_ptr(8'd20, "R5");
    read_seq(20, 3, "R5 wrap 21 to 0");
  endtask

  task automatic t_extra;
    bit ack;
    i2c_start;
    send_byte(8'h74, 1'b0, ack); chk("R3 address ACK", ack, 1);
    send_byte(8'd7, 1'b0, ack);  chk("R3 index ACK", ack, 1);
    send_byte(8'd2, 1'b0, ack);  chk("R3 extra byte ACK", ack, 1);
    send_byte(8'd3, 1'b0, ack);  chk("R3 second extra byte ACK", ack, 1);
    i2c_stop;
    read_seq(7, 1, "R3 index unchanged by extra bytes");
  endtask

  task automatic t_range;
    set_ptr(8'd30, "R2");
    read_seq(0, 1, "R2 index 30 falls back to 0");
    set_ptr(8'd21, "R2");
    read_seq(21, 1, "R2 index 21 accepted");
  endtask

  task automatic t_badaddr;
    bit ack;
    i2c_start;
    send_byte(8'h50, 1'b0, ack); chk("R1 foreign address NACK", ack, 0);
    send_byte(8'h00, 1'b0, ack); chk("R1 no ACK after foreign address", ack, 0);
    i2c_stop;
    i2c_start;
    send_byte(8'h77, 1'b0, ack); chk("R1 address 0x3B read NACK", ack, 0);
    i2c_stop;
    chk("R1 SDA released after mismatch", sda_oe, 0);
  endtask

  task automatic t_nack;
    bit ack;
    logic [7:0] v;
    set_ptr(8'd3, "R6");
    i2c_start;
    send_byte(8'h75, 1'b0, ack); chk("R6 read address ACK", ack, 1);
    recv_byte(1'b0, v);          chk("R6 byte before NACK", v, expv(3));
    recv_byte(1'b0, v);          chk("R6 bus stays high after NACK", v, 8'hFF);
    chk("R6 SDA not driven after NACK", sda_oe, 0);
    i2c_stop;
  endtask

  task automatic t_rstart;
    bit ack;
    logic [7:0] v;
    i2c_start;
    send_byte(8'h74, 1'b0, ack); chk("R7 write address ACK", ack, 1);
    send_byte(8'd12, 1'b0, ack); chk("R7 index ACK", ack, 1);
    i2c_start;
    send_byte(8'h75, 1'b0, ack); chk("R7 ACK after repeated START", ack, 1);
    recv_byte(1'b0, v);          chk("R7 data after repeated START", v, expv(12));
    i2c_stop;
  endtask

  task automatic t_glitch;
    bit ack;
    i2c_start;
    send_byte(8'h74, 1'b1, ack); chk("R8 glitched address ACK", ack, 1);
    send_byte(8'd9, 1'b1, ack);  chk("R8 glitched index ACK", ack, 1);
    i2c_stop;
    read_seq(9, 1, "R8 index written under glitches");
  endtask

  task automatic t_abort;
    bit ack;
    set_ptr(8'd15, "R11");
    i2c_start;
    send_byte(8'h74, 1'b0, ack); chk("R11 address ACK", ack, 1);
    for (int i = 0; i < 4; i++) bit_out(1'b0, 1'b0);
    i2c_stop;
    chk("R11 SDA released after aborting STOP", sda_oe, 0);
    read_seq(15, 1, "R11 index kept after aborted write");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_burst;
    t_snapshot;
    t_wrap;
    t_extra;
    t_range;
    t_badaddr;
    t_nack;
    t_rstart;
    t_glitch;
    t_abort;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule